// File: doc/BRIEF.md
# Windowed Bus-to-DMA Address Translator

This block turns an address seen on an I/O bus into a system DMA address. It holds a small set of programmable windows. Each window has three 64-bit registers: a base (whose bit 0 enables the window and bit 1 picks page-table mode), a size mask, and a translated base. When a request arrives, the windows are searched in ascending index order. The first window that matches and is enabled maps the address. The mapping is either a direct splice of the translated base and the low address bits, or a lookup of one page-table entry in memory.

A window in direct mode finishes one cycle after its request is accepted. A window in page-table mode first builds the entry's memory address and raises a read request. It holds that request until the response arrives. It then joins the returned page number to the 13-bit page offset. An address that finds no enabled window leaves the block unchanged. The block is busy from acceptance until its done pulse, so it serves one request at a time.

Top module: `dma_xlat_top`

## Requirements
- R1: After reset every window register is zero, busy, done and mem_req are low, and any request therefore returns the bus address unchanged.
- R2: A window matches when the bus address and its base register agree in every bit of 31:20 whose mask-register bit is clear. Bus-address bits outside 31:20 play no part in the match.
- R3: A matching window whose base bit 0 is clear is skipped, and the search continues with the next index.
- R4: When several enabled windows match, the one with the lowest index supplies the translation.
- R5: In direct mode (base bit 1 clear), let P be (mask & 0xFFF00000) | 0xFFFFF. The result is (translated base & ~P) | (bus address & P).
- R6: In page-table mode (base bit 1 set), mem_req rises in the cycle after acceptance. mem_addr is (translated base & ~(((mask & 0xFFF00000) >> 10) | 0x3FF)) | ((bus & ((mask & 0xFFF00000) | 0xFE000)) >> 10). mem_req and mem_addr then hold steady until mem_rvalid is seen.
- R7: In page-table mode the result is ((mem_rdata & ~1) << 12) | (bus address & 0x1FFF).
- R8: Every translated result, direct or page-table, is cut to its low 34 bits, and bits 63:34 read zero.
- R9: When no enabled window matches, the result equals the full 64-bit bus address.
- R10: done is a single-cycle pulse. It comes one cycle after acceptance for direct and miss results, and one cycle after the cycle in which mem_rvalid is high for page-table results.
- R11: While busy is high, req_valid is ignored. No extra done pulse or memory read follows, and the pending result is not altered.
- R12: A register write selects the register with cfg_sel: 0 is base, 1 is mask, 2 is translated base. The value 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_win | input | 2 | Window index for the write |
| cfg_sel | input | 2 | Register select: 0 base, 1 mask, 2 translated base, 3 none |
| cfg_wdata | input | 64 | Write data |
| req_valid | input | 1 | Translation request, accepted when busy is low |
| req_addr | input | 64 | Bus address to translate |
| busy | output | 1 | High from acceptance up to and including the done cycle |
| done | output | 1 | One-cycle pulse marking a valid result |
| res_addr | output | 64 | Translated (or unchanged) address |
| mem_req | output | 1 | Page-table entry read request |
| mem_addr | output | 64 | Page-table entry address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read response data (page-table entry) |

## Verification
A wrong window choice shows at res_addr in the first done pulse after the request. So does a wrong mask or a mode bit read at the wrong position. Each scenario places one deciding window next to a decoy that would give a different value. A corrupted sequencer state shows at once as a missing or doubled done, or a mem_req that drops before its response. A wrong entry address shows on mem_addr in the cycle after acceptance, before any response is given.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
    localparam int ADDR_W = 64;
    localparam int DMA_W  = 34;

    // window size field and fixed mapping constants
    localparam logic [ADDR_W-1:0] WIN_FIELD  = 64'h0000_0000_FFF0_0000;
    localparam logic [ADDR_W-1:0] DIRECT_LOW = 64'h0000_0000_000F_FFFF;
    localparam logic [ADDR_W-1:0] PTE_IDX    = 64'h0000_0000_000F_E000;
    localparam logic [ADDR_W-1:0] PTE_ALIGN  = 64'h0000_0000_0000_03FF;
    localparam logic [ADDR_W-1:0] PAGE_OFF   = 64'h0000_0000_0000_1FFF;
    localparam int PTE_SHIFT  = 10;
    localparam int PAGE_SHIFT = 12;
    localparam logic [ADDR_W-1:0] DMA_KEEP = (64'd1 << DMA_W) - 64'd1;

    // bit positions inside the base register
    localparam int EN_BIT = 0;
    localparam int SG_BIT = 1;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_TBASE = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } xlat_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] tbase;
    } win_cfg_t;
endpackage

// File: rtl/dma_xlat_win_regs.sv
module dma_xlat_win_regs
    import dma_xlat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_win,
    input  logic [1:0]               cfg_sel,
    input  logic [ADDR_W-1:0]        cfg_wdata,
    output win_cfg_t [NUM_WIN-1:0]   cfg_o
);
    win_cfg_t [NUM_WIN-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (cfg_win == IDX_W'(i)) begin
                    case (cfg_sel_e'(cfg_sel))
                        SEL_BASE:  cfg_d[i].base  = cfg_wdata;
                        SEL_MASK:  cfg_d[i].mask  = cfg_wdata;
                        SEL_TBASE: cfg_d[i].tbase = cfg_wdata;
                        default:   ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R12
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd3) |=> $stable(cfg_q));
endmodule

// File: rtl/dma_xlat_win_eval.sv
module dma_xlat_win_eval
    import dma_xlat_pkg::*;
(
    input  win_cfg_t            cfg,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                hit,
    output logic                sg,
    output logic [ADDR_W-1:0]   direct_addr,
    output logic [ADDR_W-1:0]   pte_addr
);
    logic [ADDR_W-1:0] cmp_mask;
    logic [ADDR_W-1:0] size_bits;
    logic [ADDR_W-1:0] pass_mask;
    logic [ADDR_W-1:0] tb_keep;
    logic [ADDR_W-1:0] idx_mask;
    logic              match;

    always_comb begin
        size_bits   = cfg.mask & WIN_FIELD;
        cmp_mask    = ~cfg.mask & WIN_FIELD;
        match       = (bus_addr & cmp_mask) == (cfg.base & cmp_mask);
        hit         = match && cfg.base[EN_BIT];
        sg          = cfg.base[SG_BIT];
        pass_mask   = size_bits | DIRECT_LOW;
        direct_addr = ((cfg.tbase & ~pass_mask) | (bus_addr & pass_mask)) & DMA_KEEP;
        tb_keep     = ~((size_bits >> PTE_SHIFT) | PTE_ALIGN);
        idx_mask    = size_bits | PTE_IDX;
        pte_addr    = (cfg.tbase & tb_keep) | ((bus_addr & idx_mask) >> PTE_SHIFT);
    end

    // R8
    direct_trunc_chk: assert final (direct_addr[ADDR_W-1:DMA_W] == '0);
endmodule

// File: rtl/dma_xlat_first_hit.sv
module dma_xlat_first_hit #(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hit,
    output logic [NUM_WIN-1:0] grant,
    output logic               any_hit,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        grant   = '0;
        any_hit = 1'b0;
        idx     = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit[i] && !any_hit) begin
                any_hit  = 1'b1;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

    // R4
    grant_onehot_chk: assert final ($onehot0(grant));
    // R4
    grant_lowest_chk: assert final (((grant - 1'b1) & hit & {NUM_WIN{any_hit}}) == '0);
endmodule

// File: rtl/dma_xlat_top.sv
module dma_xlat_top
    import dma_xlat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_win,
    input  logic [1:0]         cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  res_addr,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [ADDR_W-1:0]  mem_rdata
);
    typedef struct packed {
        xlat_state_e       st;
        logic [ADDR_W-1:0] bus;
        logic [ADDR_W-1:0] res;
        logic [ADDR_W-1:0] maddr;
        logic              mreq;
    } ctl_t;

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hit, sg, grant;
    logic [ADDR_W-1:0]      direct_a [NUM_WIN];
    logic [ADDR_W-1:0]      pte_a    [NUM_WIN];
    logic                   any_hit;
    logic [IDX_W-1:0]       sel_idx;
    logic                   sel_sg;
    logic [ADDR_W-1:0]      sel_direct, sel_pte;
    ctl_t                   c_d, c_q;

    dma_xlat_win_regs #(.NUM_WIN(NUM_WIN)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_win   (cfg_win),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        dma_xlat_win_eval i_eval (
            .cfg         (cfg[w]),
            .bus_addr    (req_addr),
            .hit         (hit[w]),
            .sg          (sg[w]),
            .direct_addr (direct_a[w]),
            .pte_addr    (pte_a[w])
        );
    end

    dma_xlat_first_hit #(.NUM_WIN(NUM_WIN)) i_pick (
        .hit     (hit),
        .grant   (grant),
        .any_hit (any_hit),
        .idx     (sel_idx)
    );

    always_comb begin
        sel_sg     = 1'b0;
        sel_direct = '0;
        sel_pte    = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                sel_sg     = sg[i];
                sel_direct = direct_a[i];
                sel_pte    = pte_a[i];
            end
        end
    end

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.bus = req_addr;
                    if (any_hit && sel_sg) begin
                        c_d.st    = ST_FETCH;
                        c_d.mreq  = 1'b1;
                        c_d.maddr = sel_pte;
                    end else begin
                        c_d.st  = ST_RESP;
                        c_d.res = any_hit ? sel_direct : req_addr;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rvalid) begin
                    c_d.mreq = 1'b0;
                    c_d.res  = (((mem_rdata & ~64'd1) << PAGE_SHIFT)
                               | (c_q.bus & PAGE_OFF)) & DMA_KEEP;
                    c_d.st   = ST_RESP;
                end
            end
            ST_RESP:  c_d.st = ST_IDLE;
            default:  c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign busy     = (c_q.st != ST_IDLE);
    assign done     = (c_q.st == ST_RESP);
    assign res_addr = c_q.res;
    assign mem_req  = c_q.mreq;
    assign mem_addr = c_q.maddr;

    // R10
    direct_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !(any_hit && sel_sg)) |=> done);
    // R10
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (done && !mem_req));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !mem_rvalid) |=> ($stable(res_addr) && !done));
    // R6
    sg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && any_hit && sel_sg) |=> (mem_req && !done));
endmodule

// File: tb/test_dma_xlat_top.sv
`timescale 1ns/1ps
module test_dma_xlat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        busy, done, mem_req;
    logic [63:0] res_addr, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    logic [63:0] sh_base [4];
    logic [63:0] sh_mask [4];
    logic [63:0] sh_tb   [4];

    always #2.5 clk = ~clk;

    dma_xlat_top i_dma_xlat_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .busy(busy), .done(done), .res_addr(res_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // kind: 0 miss, 1 direct, 2 page-table
    function automatic void model(input logic [63:0] bus, output int kind,
                                  output logic [63:0] res, output logic [63:0] pte);
        logic [63:0] cm, sz, p;
        kind = 0; res = bus; pte = '0;
        for (int i = 0; i < 4; i++) begin
            cm = ~sh_mask[i] & 64'hFFF0_0000;
            sz = sh_mask[i] & 64'hFFF0_0000;
            if (kind == 0 && sh_base[i][0] && ((bus & cm) == (sh_base[i] & cm))) begin
                if (sh_base[i][1]) begin
                    kind = 2;
                    pte = (sh_tb[i] & ~((sz >> 10) | 64'h3FF)) | ((bus & (sz | 64'hFE000)) >> 10);
                end else begin
                    kind = 1;
                    p = sz | 64'hFFFFF;
                    res = ((sh_tb[i] & ~p) | (bus & p)) & 64'h3_FFFF_FFFF;
                end
            end
        end
    endfunction

    task automatic wr(int w, int sel, logic [63:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 2'(w); cfg_sel = 2'(sel); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) sh_base[w] = v;
        if (sel == 1) sh_mask[w] = v;
        if (sel == 2) sh_tb[w] = v;
    endtask

    // one request; rdata/delay used only for page-table windows
    task automatic xlat(string tag, logic [63:0] bus, logic [63:0] rdata, int delay);
        int kind;
        logic [63:0] exp, pte;
        model(bus, kind, exp, pte);
        @(negedge clk);
        req_valid = 1'b1; req_addr = bus;
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == 2) begin
            chk({tag, " R6 mem_req"}, {63'd0, mem_req}, 64'd1);
            chk({tag, " R6 mem_addr"}, mem_addr, pte);
            chk({tag, " R10 no early done"}, {63'd0, done}, 64'd0);
            for (int k = 0; k < delay; k++) begin
                @(negedge clk);
                chk({tag, " R6 hold"}, {63'd0, mem_req}, 64'd1);
            end
            mem_rvalid = 1'b1; mem_rdata = rdata;
            @(negedge clk);
            mem_rvalid = 1'b0;
            exp = (((rdata & ~64'd1) << 12) | (bus & 64'h1FFF)) & 64'h3_FFFF_FFFF;
            chk({tag, " R6 req drop"}, {63'd0, mem_req}, 64'd0);
        end
        chk({tag, " R10 done"}, {63'd0, done}, 64'd1);
        chk({tag, " result"}, res_addr, exp);
        @(negedge clk);
        chk({tag, " R10 pulse"}, {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin sh_base[i] = '0; sh_mask[i] = '0; sh_tb[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 done", {63'd0, done}, 64'd0);
        chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
        rst_n = 1'b1;
        xlat("R1 R9 reset miss", 64'hDEAD_BEEF_0123_4567, '0, 0);
    endtask

    task automatic t_direct();
        wr(0, 0, 64'h4000_0001);
        wr(0, 1, 64'h0010_0000);
        wr(0, 2, 64'hFFFF_FFFF_8000_0000);
        xlat("R2 R5 R8 direct high bits", 64'hABCD_0000_4012_3456, '0, 0);
        xlat("R2 R5 mask bit", 64'h0000_0000_4019_8765, '0, 0);
        xlat("R2 R9 outside window", 64'h0000_0000_4022_0000, '0, 0);
    endtask

    task automatic t_skip_prio();
        wr(1, 0, 64'h6000_0000);
        wr(1, 2, 64'h0000_0003_0000_0000);
        wr(2, 0, 64'h6000_0001);
        wr(2, 2, 64'h0000_0001_2340_0000);
        wr(3, 0, 64'h6000_0003);
        wr(3, 1, 64'h0030_0000);
        wr(3, 2, 64'h0000_0003_5555_0000);
        xlat("R3 R4 disabled skipped lower wins", 64'h6001_2345, '0, 0);
    endtask

    task automatic t_pagetable();
        wr(2, 0, 64'h6000_0000);
        xlat("R7 R8 page table", 64'h0000_0000_6036_ABCD, 64'hFFFF_FFFF_FFFF_F123, 3);
        xlat("R7 zero delay", 64'h0000_0000_6000_0001, 64'h0000_0000_0004_5679, 0);
    endtask

    task automatic t_busy();
        logic [63:0] exp, bus;
        bus = 64'h6020_1FFF;
        @(negedge clk);
        req_valid = 1'b1; req_addr = bus;
        @(negedge clk);
        req_addr = 64'h4000_0000;
        @(negedge clk);
        chk("R11 busy", {63'd0, busy}, 64'd1);
        chk("R11 no done", {63'd0, done}, 64'd0);
        req_valid = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = 64'h0000_0000_000A_BC01;
        @(negedge clk);
        mem_rvalid = 1'b0;
        exp = ((64'h000A_BC00 << 12) | (bus & 64'h1FFF)) & 64'h3_FFFF_FFFF;
        chk("R11 pending result", res_addr, exp);
        @(negedge clk);
        chk("R11 no extra done", {63'd0, done}, 64'd0);
        chk("R11 no extra read", {63'd0, mem_req}, 64'd0);
        chk("R11 idle", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_cfg_none();
        wr(0, 3, 64'hFFFF_FFFF_FFFF_FFFF);
        xlat("R12 select 3 ignored", 64'h0000_0000_4012_3456, '0, 0);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_skip_prio();
        t_pagetable();
        t_busy();
        t_cfg_none();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule